// File: doc/BRIEF.md
# Selectable-Prescale UART Bit-Rate Tick Generator

This block produces a single-cycle bit-rate strobe for a UART transmitter and receiver. It runs in one clock domain. Two reference sources reach it as clock-enable strobes: a crystal strobe (nominally 24 MHz) and an alternate strobe. Each source passes through its own fixed prescaler. A programmable divisor then counts prescaled periods and fires the tick. The crystal path normally divides by 3. When the build parameter `HAS_HALF_PRESCALE` is set, a register bit switches that path to divide by 2. With a 24 MHz crystal this makes exact rates such as 3 Mbaud reachable, which the 8 MHz /3 path cannot hit.

Software writes a 32-bit rate word through a simple write port and can read the last written word back. A written word is held pending and takes effect only while the transmitter reports idle. This keeps a bit period from being cut short during a transfer. When the word is applied, both counters restart from zero.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the read-back word is zero and `bitTick` stays low, because the enable bit is cleared.
- R2: With divisor field value N (rate word bits [22:0]), one tick is produced every N+1 prescaled reference periods.
- R3: While enable (bit 23) of the applied word is 0, no tick is produced and both counters are held at zero.
- R4: Bit 24 set selects the crystal strobe `xtalStb`. Bit 24 clear selects the alternate strobe `altStb`, prescaled by 4. The unselected strobe has no effect.
- R5: On the crystal path with bit 27 clear, the prescaler divides by 3.
- R6: When `HAS_HALF_PRESCALE` is 1 and bit 27 is set, the crystal path divides by 2. Strobing every cycle with N=3 then gives a tick every 8 cycles.
- R7: When `HAS_HALF_PRESCALE` is 0, bit 27 reads back as 0 and the crystal path always divides by 3.
- R8: A written word stays pending, and the previous rate keeps running unchanged, until `txIdle` is high in a cycle with no write.
- R9: The apply edge clears both counters. With every-cycle strobes, the first tick of the new rate appears exactly one full new period (prescale times (N+1) cycles) after the apply edge.
- R10: `bitTick` is high for exactly one clock cycle per bit period.
- R11: A divisor field of 0 gives one tick per prescaled period, which is the highest rate.
- R12: `cfgRdData` returns the last written word, masked as in R7, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the rate word |
| cfgWrData | input | 32 | Rate word: [22:0] divisor minus one, 23 enable, 24 crystal select, 27 half prescale |
| cfgRdData | output | 32 | Last written rate word |
| txIdle | input | 1 | Transmitter idle; allows a pending word to be applied |
| xtalStb | input | 1 | Crystal reference clock-enable strobe |
| altStb | input | 1 | Alternate reference clock-enable strobe |
| bitTick | output | 1 | One-cycle bit-rate tick |

## Verification
A wrong prescaler or divisor count shows up at the very first tick after an apply, because that tick lands a whole number of cycles off the period predicted from the rate word. A counter that is not cleared on apply or disable shows up in the same first interval. A word applied while `txIdle` is low shows up as early ticks at the new spacing during the pending window. A tick held high for two cycles is caught in the cycle after it rises.

// File: rtl/baud_gen_pkg.sv
`timescale 1ns/1ps
package baud_gen_pkg;
  localparam int CFG_W    = 32;
  localparam int DIV_W    = 23;
  localparam int EN_BIT   = 23;
  localparam int XTAL_BIT = 24;
  localparam int HALF_BIT = 27;

  localparam int XTAL_PRE      = 3;
  localparam int XTAL_HALF_PRE = 2;
  localparam int ALT_PRE       = 4;
  localparam int PRE_W         = $clog2(ALT_PRE + 1);

  // decoded rate fields held by the control side
  typedef struct packed {
    logic             enable;
    logic             useXtal;
    logic             halfPre;
    logic [DIV_W-1:0] divN;
  } rate_cfg_t;

  // strobes and fields handed to the datapath
  typedef struct packed {
    logic      restart;
    rate_cfg_t cfg;
  } rate_ctl_t;
endpackage

// File: rtl/baud_cfg_ctrl.sv
`timescale 1ns/1ps
module baud_cfg_ctrl
  import baud_gen_pkg::*;
#(
  parameter bit HAS_HALF = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             txIdle,
  output logic [CFG_W-1:0] cfgRdData,
  output rate_ctl_t        rateCtl
);
  logic [CFG_W-1:0] wrMask;
  logic [CFG_W-1:0] shadowQ;
  rate_cfg_t        activeQ;
  rate_cfg_t        shadowDec;
  logic             pendingQ;
  logic             applyNow;

  generate
    if (HAS_HALF) begin : g_half
      assign wrMask = '1;
    end else begin : g_noHalf
      assign wrMask = ~(CFG_W'(1) << HALF_BIT);
    end
  endgenerate

  assign applyNow = pendingQ && txIdle && !cfgWrEn;

  always_comb begin
    shadowDec.enable  = shadowQ[EN_BIT];
    shadowDec.useXtal = shadowQ[XTAL_BIT];
    shadowDec.halfPre = shadowQ[HALF_BIT];
    shadowDec.divN    = shadowQ[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ  <= '0;
      activeQ  <= '0;
      pendingQ <= 1'b0;
    end else if (cfgWrEn) begin
      shadowQ  <= cfgWrData & wrMask;
      pendingQ <= 1'b1;
    end else if (applyNow) begin
      activeQ  <= shadowDec;
      pendingQ <= 1'b0;
    end
  end

  assign cfgRdData       = shadowQ;
  assign rateCtl.restart = applyNow;
  assign rateCtl.cfg     = activeQ;

  // R8
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txIdle |=> $stable(activeQ));

  // R12
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == ($past(cfgWrData) & wrMask));

  generate
    if (!HAS_HALF) begin : g_noHalfChk
      // R7
      half_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
        !cfgRdData[HALF_BIT] && !activeQ.halfPre);
    end
  endgenerate
endmodule

// File: rtl/baud_tick_path.sv
`timescale 1ns/1ps
module baud_tick_path
  import baud_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      xtalStb,
  input  logic      altStb,
  input  rate_ctl_t rateCtl,
  output logic      bitTick
);
  logic             refStb;
  logic [PRE_W-1:0] preLast;
  logic             preWrap;
  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divCnt;
  logic             tickQ;
  logic             holdClr;

  assign refStb  = rateCtl.cfg.useXtal ? xtalStb : altStb;
  assign preLast = !rateCtl.cfg.useXtal ? PRE_W'(ALT_PRE - 1)
                 : rateCtl.cfg.halfPre  ? PRE_W'(XTAL_HALF_PRE - 1)
                 :                        PRE_W'(XTAL_PRE - 1);
  assign preWrap = refStb && (preCnt == preLast);
  assign holdClr = rateCtl.restart || !rateCtl.cfg.enable;

  always_ff @(posedge clk) begin
    if (!rstN || holdClr) begin
      preCnt <= '0;
      divCnt <= '0;
      tickQ  <= 1'b0;
    end else begin
      tickQ <= 1'b0;
      if (refStb) begin
        if (preWrap) begin
          preCnt <= '0;
          if (divCnt == rateCtl.cfg.divN) begin
            divCnt <= '0;
            tickQ  <= 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  assign bitTick = tickQ;

  // R10
  single_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickQ |=> !tickQ);

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rateCtl.cfg.enable |=> !tickQ && preCnt == '0 && divCnt == '0);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateCtl.restart |=> preCnt == '0 && divCnt == '0 && !tickQ);

  // R2
  div_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateCtl.cfg.enable && !rateCtl.restart |-> divCnt <= rateCtl.cfg.divN);

  // R5
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateCtl.cfg.enable && !rateCtl.restart |-> preCnt <= preLast);
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
  import baud_gen_pkg::*;
#(
  parameter bit HAS_HALF_PRESCALE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        txIdle,
  input  logic        xtalStb,
  input  logic        altStb,
  output logic        bitTick
);
  rate_ctl_t rateCtl;

  baud_cfg_ctrl #(.HAS_HALF(HAS_HALF_PRESCALE)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .txIdle    (txIdle),
    .cfgRdData (cfgRdData),
    .rateCtl   (rateCtl)
  );

  baud_tick_path i_path (
    .clk     (clk),
    .rstN    (rstN),
    .xtalStb (xtalStb),
    .altStb  (altStb),
    .rateCtl (rateCtl),
    .bitTick (bitTick)
  );
endmodule

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData, nhRdData;
  logic        txIdle = 1'b1;
  logic        xtalStb = 1'b1;
  logic        altStb = 1'b1;
  logic        bitTick, nhTick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int marker = 0;
  int tickSeen = 0;
  int nhCount = 0;
  bit ignore = 1'b1;
  bit prevTick = 1'b0;
  bit done = 1'b0;
  int expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen #(.HAS_HALF_PRESCALE(1'b1)) i_baud_tick_gen (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .txIdle(txIdle), .xtalStb(xtalStb),
    .altStb(altStb), .bitTick(bitTick));

  baud_tick_gen #(.HAS_HALF_PRESCALE(1'b0)) i_baud_tick_gen_noHalf (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(nhRdData), .txIdle(txIdle), .xtalStb(xtalStb),
    .altStb(altStb), .bitTick(nhTick));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit x, input bit h, input int n);
    return {4'b0, h, 2'b0, x, en, n[22:0]};
  endfunction

  // monitor: pops expected tick spacing and compares with observed
  always @(negedge clk) begin
    if (rstN) begin
      if (bitTick) begin
        if (prevTick) chk(1'b0, "R10", 2, 1);
        if (!ignore) begin
          tickSeen++;
          if (expQ.size() == 0) chk(1'b0, "R2 unexpected tick", cyc - marker, 0);
          else begin
            int e;
            e = expQ.pop_front();
            chk((cyc - marker) == e, "R2 tick spacing", cyc - marker, e);
          end
          marker = cyc;
        end
      end
      prevTick = bitTick;
      if (nhTick) nhCount++;
    end
  end

  task automatic waitCyc(input int n);
    while (cyc < n) begin
      @(posedge clk); #2;
    end
  endtask

  // driver: write a word, apply it, push expected spacings, check count
  task automatic runPhase(input logic [31:0] cfg, input int period, input int count,
                          input int window, input string req);
    int k;
    ignore = 1'b1;
    @(posedge clk); #2;
    cfgWrEn = 1'b1; cfgWrData = cfg;
    @(posedge clk); #2;
    cfgWrEn = 1'b0;
    chk(cfgRdData == cfg, "R12 readback", cfgRdData, cfg);
    @(posedge clk); #2;
    k = cyc;
    marker = k;
    tickSeen = 0;
    nhCount = 0;
    expQ.delete();
    for (int i = 0; i < count; i++) expQ.push_back(period);
    ignore = 1'b0;
    if (count > 0) waitCyc(k + count * period);
    else waitCyc(k + window);
    @(negedge clk); #1;
    chk(tickSeen == count, req, tickSeen, count);
    ignore = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfgRdData == 32'h0, "R1 readback", cfgRdData, 0);
    chk(bitTick == 1'b0, "R1 tick", bitTick, 0);
    tickSeen = 0; ignore = 1'b0;
    repeat (40) @(negedge clk);
    chk(tickSeen == 0, "R1 no ticks", tickSeen, 0);
    ignore = 1'b1;

    // R5: crystal /3, N=4 -> 15 cycles
    runPhase(mk(1, 1, 0, 4), 15, 3, 0, "R5 /3 tick count");
    // R6: crystal /2, N=3 -> 8 cycles; noHalf copy keeps /3 -> 12
    runPhase(mk(1, 1, 1, 3), 8, 4, 0, "R6 /2 tick count");
    chk(nhCount == 2, "R7 no effect when absent", nhCount, 2);
    chk(nhRdData == mk(1, 1, 0, 3), "R7 bit27 reads zero", nhRdData, mk(1, 1, 0, 3));
    // R11: N=0 with /2 -> 2 cycles
    runPhase(mk(1, 1, 1, 0), 2, 6, 0, "R11 max rate count");
    // R4: alternate /4, N=2 -> 12 cycles
    runPhase(mk(1, 0, 0, 2), 12, 3, 0, "R4 alternate /4 count");
    // R4: alternate selected but its strobe is quiet
    altStb = 1'b0;
    runPhase(mk(1, 0, 0, 1), 0, 0, 50, "R4 unselected strobe ignored");
    altStb = 1'b1;
    // R3: enable clear
    runPhase(mk(0, 1, 0, 1), 0, 0, 50, "R3 disabled no ticks");

    // R8 / R9: pending word held while transmitter busy
    runPhase(mk(1, 1, 1, 1), 4, 3, 0, "R9 phase A count");
    e = marker;
    @(posedge clk); #2;
    txIdle = 1'b0;
    cfgWrEn = 1'b1; cfgWrData = mk(1, 1, 0, 2);
    tickSeen = 0;
    expQ.delete();
    for (int i = 0; i < 4; i++) expQ.push_back(4);
    ignore = 1'b0;
    @(posedge clk); #2;
    cfgWrEn = 1'b0;
    waitCyc(e + 16);
    @(negedge clk); #1;
    chk(tickSeen == 4, "R8 old rate kept while busy", tickSeen, 4);
    chk(cfgRdData == mk(1, 1, 0, 2), "R12 pending readback", cfgRdData, mk(1, 1, 0, 2));
    @(posedge clk); #2;
    ignore = 1'b1;
    txIdle = 1'b1;
    @(posedge clk); #2;
    marker = cyc;
    tickSeen = 0;
    expQ.delete();
    for (int i = 0; i < 3; i++) expQ.push_back(9);
    ignore = 1'b0;
    waitCyc(marker + 27);
    @(negedge clk); #1;
    chk(tickSeen == 3, "R9 new rate after apply", tickSeen, 3);
    ignore = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule